// File: doc/BRIEF.md
# Shared-Term Programmable AND-OR Array

This block is a configurable two-level logic array. Each array input enters the AND plane twice, once as its true value and once inverted. A stored mask picks which of these literals take part in each product term. A second stored mask picks which product terms take part in each sum term. A single product term may be enabled in any number of sum-term masks, so logic that is common to several functions is built once and reused, not copied.

Sum terms are grouped in fours for the downstream cells. Sum index s belongs to cell s/4, and s%4 selects its slot: 0, 1, 2 or 3 for slots A to D. The path from inputs to sum outputs is purely combinational.

The masks are loaded one row at a time through a word-wide write port. After each write the rest of the array keeps working. The `valid_o` flag tells downstream logic when the outputs reflect a settled configuration. The default size is 38 inputs, 67 product terms and 50 sum terms.

Top module: `pla_array`

## Requirements
- R1: AND-plane row p holds the literal mask of product term p. Bit 2k selects input k true and bit 2k+1 selects input k complemented. The product term is 1 exactly when every selected literal is 1.
- R2: A product term whose literal mask is all zero evaluates to 0.
- R3: A product term that selects both the true and the complement of the same input evaluates to 0 for every input value.
- R4: OR-plane row s holds the product mask of sum term s, where bit p selects product term p. The sum term is the OR of the selected product terms. One product term may be selected by many sum terms at the same time.
- R5: A sum term whose product mask is all zero evaluates to 0.
- R6: While reset is asserted, all masks are cleared. After reset, every `sum_o` bit is 0 and `valid_o` is 0.
- R7: A write needs `cfg_we_i` high at a rising clock edge. `cfg_plane_i` selects the plane: 0 for the AND plane, 1 for the OR plane. `cfg_addr_i` selects the row, and the new row takes effect right after that edge. A row address at or beyond the plane's row count changes nothing.
- R8: `valid_o` is 0 after any clock edge at which `cfg_we_i` was high. It is 1 after a clock edge, outside reset, at which `cfg_we_i` was low.
- R9: `sum_o` follows `in_i` with no clock edge in between. With no write, a stable input gives a stable output.
- R10: With default sizes, a 16-bit inequality between inputs 0..15 and inputs 16..31 fits in 32 shared product terms and one sum term. Each product term is a·¬b or ¬a·b for one bit pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes and the valid flag |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Row write enable |
| cfg_plane_i | input | 1 | Plane select: 0 for AND, 1 for OR |
| cfg_addr_i | input | AW | Row address within the selected plane |
| cfg_data_i | input | DW | Row contents; low 2·N_IN bits are used for AND, low N_PT bits for OR |
| in_i | input | N_IN | Array inputs |
| sum_o | output | N_SUM | Sum-term outputs, four per cell |
| valid_o | output | 1 | Outputs reflect a configuration with no write in the previous cycle |

## Verification
The assertions assume that inputs change only away from the clock edge. The output-stability property also assumes that the configuration changes only through sampled writes. The bench drives every input on the falling edge, and it holds write data stable over the rising edge at which `cfg_we_i` is sampled. The random masks are kept sparse, from one to four literals and a few products per row, so that product terms fire often enough to exercise sharing. Out-of-range addresses are written only in directed cases, and their effect is judged by comparing the outputs against the in-range model.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic {
    PLANE_AND = 1'b0,
    PLANE_OR  = 1'b1
  } plane_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN = 38,
  parameter int N_PT = 67,
  parameter int AW   = 7,
  localparam int NL  = 2 * N_IN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [NL-1:0]  data_i,
  input  logic [N_IN-1:0] in_i,
  output logic [N_PT-1:0] pt_o
);
  logic [NL-1:0] lit;

  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    assign lit[2*k]   = in_i[k];
    assign lit[2*k+1] = ~in_i[k];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [NL-1:0] mask_q;
    logic          clash;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mask_q <= '0;
      else if (we_i && addr_i == AW'(p))     mask_q <= data_i;
    end

    // empty mask must not yield an all-true AND
    assign pt_o[p] = (|mask_q) & (&(lit | ~mask_q));

    always_comb begin
      clash = 1'b0;
      for (int k = 0; k < N_IN; k++) clash = clash | (mask_q[2*k] & mask_q[2*k+1]);
    end

    assert_empty_pt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q == '0) |-> !pt_o[p]);
    assert_clash_pt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clash |-> !pt_o[p]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT  = 67,
  parameter int N_SUM = 50,
  parameter int AW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [N_PT-1:0]  data_i,
  input  logic [N_PT-1:0]  pt_i,
  output logic [N_SUM-1:0] sum_o
);
  for (genvar s = 0; s < N_SUM; s++) begin : g_sum
    logic [N_PT-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       mask_q <= '0;
      else if (we_i && addr_i == AW'(s)) mask_q <= data_i;
    end

    assign sum_o[s] = |(mask_q & pt_i);

    assert_empty_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q == '0) |-> !sum_o[s]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN  = 38,
  parameter int N_PT  = 67,
  parameter int N_SUM = 50,
  localparam int NL   = 2 * N_IN,
  localparam int DW   = max_int(NL, N_PT),
  localparam int AW   = $clog2(max_int(N_PT, N_SUM))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_plane_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_SUM-1:0] sum_o,
  output logic             valid_o
);
  logic [N_PT-1:0] pt;
  logic            we_and, we_or;
  logic            valid_q;

  assign we_and = cfg_we_i && (plane_e'(cfg_plane_i) == PLANE_AND);
  assign we_or  = cfg_we_i && (plane_e'(cfg_plane_i) == PLANE_OR);

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT), .AW(AW)) u_and (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_and),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i[NL-1:0]),
    .in_i   (in_i),
    .pt_o   (pt)
  );

  pla_or_plane #(.N_PT(N_PT), .N_SUM(N_SUM), .AW(AW)) u_or (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_or),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i[N_PT-1:0]),
    .pt_i   (pt),
    .sum_o  (sum_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= !cfg_we_i;
  end

  assign valid_o = valid_q;

  assert_valid_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !valid_o);
  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> valid_o);
  assert_sum_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(in_i)) |-> $stable(sum_o));
endmodule

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
  localparam int N_IN  = 38;
  localparam int N_PT  = 67;
  localparam int N_SUM = 50;
  localparam int NL    = 2 * N_IN;
  localparam int DW    = (NL > N_PT) ? NL : N_PT;
  localparam int AW    = $clog2((N_PT > N_SUM) ? N_PT : N_SUM);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic             cfg_plane_i = 1'b0;
  logic [AW-1:0]    cfg_addr_i = '0;
  logic [DW-1:0]    cfg_data_i = '0;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_SUM-1:0] sum_o;
  logic             valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [NL-1:0]   m_and [N_PT];
  logic [N_PT-1:0] m_or  [N_SUM];

  always #10 clk = ~clk;

  pla_array #(.N_IN(N_IN), .N_PT(N_PT), .N_SUM(N_SUM)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_plane_i(cfg_plane_i),
    .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i), .in_i(in_i),
    .sum_o(sum_o), .valid_o(valid_o)
  );

  function automatic logic [N_SUM-1:0] model(input logic [N_IN-1:0] x);
    logic [N_PT-1:0]  pt;
    logic [N_SUM-1:0] s;
    for (int p = 0; p < N_PT; p++) begin
      logic ok;
      ok = (m_and[p] != '0);
      for (int k = 0; k < N_IN; k++) begin
        if (m_and[p][2*k]   && !x[k]) ok = 1'b0;
        if (m_and[p][2*k+1] &&  x[k]) ok = 1'b0;
      end
      pt[p] = ok;
    end
    for (int i = 0; i < N_SUM; i++) s[i] = |(m_or[i] & pt);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req);
    logic [N_SUM-1:0] e;
    e = model(in_i);
    check(sum_o === e, req, 128'(sum_o), 128'(e));
  endtask

  task automatic wr(input bit plane, input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_plane_i = plane; cfg_addr_i = AW'(addr); cfg_data_i = data;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (!plane && addr < N_PT)  m_and[addr] = data[NL-1:0];
    if (plane && addr < N_SUM)  m_or[addr]  = data[N_PT-1:0];
  endtask

  function automatic logic [N_IN-1:0] rnd_in();
    logic [N_IN-1:0] v;
    for (int k = 0; k < N_IN; k++) v[k] = 1'($urandom);
    return v;
  endfunction

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < N_PT; p++) m_and[p] = '0;
    for (int i = 0; i < N_SUM; i++) m_or[i] = '0;

    // R6 reset state
    in_i = rnd_in();
    #35;
    check(sum_o == '0, "R6 sum", 128'(sum_o), 0);
    check(valid_o == 1'b0, "R6 valid", 128'(valid_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b1, "R8 idle valid", 128'(valid_o), 1);

    // R1 single product: in0 & ~in1 into sum 0
    wr(1'b0, 0, DW'((1 << 0) | (1 << 3)));
    wr(1'b1, 0, DW'(1));
    for (int v = 0; v < 4; v++) begin
      in_i = '0; in_i[1:0] = 2'(v);
      #2;
      check(sum_o[0] == (v == 1), "R1 literal", 128'(sum_o[0]), 128'(v == 1));
    end

    // R2 empty product 5 into sum 1; R3 clash product 2 into sum 2
    wr(1'b1, 1, DW'(1 << 5));
    wr(1'b0, 2, DW'((1 << 4) | (1 << 5)));
    wr(1'b1, 2, DW'(1 << 2));
    for (int v = 0; v < 8; v++) begin
      in_i = rnd_in(); in_i[2] = v[0];
      #2;
      check(sum_o[1] == 1'b0, "R2 empty product", 128'(sum_o[1]), 0);
      check(sum_o[2] == 1'b0, "R3 clash", 128'(sum_o[2]), 0);
      check(sum_o[49] == 1'b0, "R5 empty sum", 128'(sum_o[49]), 0);
    end

    // R4 sharing: product 0 feeds sums 3,4,7
    wr(1'b1, 3, DW'(1)); wr(1'b1, 4, DW'(1)); wr(1'b1, 7, DW'(1));
    for (int v = 0; v < 4; v++) begin
      in_i = '0; in_i[1:0] = 2'(v);
      #2;
      check(sum_o[3] == (v == 1) && sum_o[4] == (v == 1) && sum_o[7] == (v == 1),
            "R4 shared", 128'(sum_o), 128'(v == 1));
    end

    // R8 valid low after a write edge
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_plane_i = 1'b1; cfg_addr_i = AW'(8); cfg_data_i = '0;
    @(negedge clk);
    check(valid_o == 1'b0, "R8 write valid", 128'(valid_o), 0);
    cfg_we_i = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b1, "R8 recover valid", 128'(valid_o), 1);

    // R7 out-of-range rows ignored
    wr(1'b0, 100, '1);
    wr(1'b1, 60, '1);
    wr(1'b0, N_PT, '1);
    wr(1'b1, N_SUM, '1);
    for (int i = 0; i < 8; i++) begin
      in_i = rnd_in(); #2;
      check_vec("R7 out of range");
    end

    // R10 16-bit inequality in sum 10
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] d;
      d = '0; d[2*i] = 1'b1; d[2*(16+i)+1] = 1'b1;
      wr(1'b0, 2*i, d);
      d = '0; d[2*i+1] = 1'b1; d[2*(16+i)] = 1'b1;
      wr(1'b0, 2*i+1, d);
    end
    wr(1'b1, 10, DW'(32'hffff_ffff));
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = (i % 2 == 0) ? a : 16'($urandom);
      if (i % 5 == 1) b = a ^ (16'(1) << (i % 16));
      in_i = rnd_in(); in_i[15:0] = a; in_i[31:16] = b;
      #2;
      check(sum_o[10] == (a != b), "R10 compare", 128'(sum_o[10]), 128'(a != b));
    end

    // R7/R1/R4/R5 random configurations, R9 combinational follow
    for (int round = 0; round < 6; round++) begin
      for (int p = 0; p < N_PT; p++) begin
        logic [DW-1:0] d;
        d = '0;
        for (int j = 0; j < 1 + int'($urandom % 4); j++) d[$urandom % NL] = 1'b1;
        wr(1'b0, p, d);
      end
      for (int i = 0; i < N_SUM - 1; i++) begin
        logic [DW-1:0] d;
        d = '0;
        for (int j = 0; j < int'($urandom % 5); j++) d[$urandom % N_PT] = 1'b1;
        wr(1'b1, i, d);
      end
      check_vec("R7 after load");
      for (int t = 0; t < 30; t++) begin
        @(posedge clk); #3;
        in_i = rnd_in();
        #2;
        check_vec("R9 combinational");
        check(sum_o[49] == 1'b0, "R5 unused sum", 128'(sum_o[49]), 0);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule